// File: doc/BRIEF.md
# Single-Slope Converter Digital Back-End with LFSR Timing and Offset Trim

This block turns comparator trip times into binary codes for a row of words that share one analog ramp. A start pulse opens a conversion window of fixed length. While the window runs, an 8-bit maximal-length shift register with XOR feedback advances once per clock and acts as a cheap time base. Each word watches its own comparator. On the first low-to-high transition inside the window, the word freezes a copy of the shift-register state. Once the window closes, each frozen code is decoded by a computed lookup table into the index of the window cycle in which the trip happened, a 6-bit value.

Comparator offsets are trimmed per word. In calibration mode the analog side converts a zero reference; each word keeps the decoded result as its offset. In ordinary conversions the stored offset is subtracted from the decoded index, and the difference is clamped at zero. A word that never trips reports full scale. One valid pulse marks the cycle in which all results have been refreshed together.

Top module: `lfsr_slope_adc`

## Requirements
- R1: After reset, `valid_o` is low, every result field is 0 and every stored offset is 0.
- R2: A `start_i` pulse seen while idle opens a window of exactly 64 clock cycles, numbered 0 to 63, starting the cycle after the accepting edge. A `start_i` pulse during the window or during the following finishing cycle is ignored and does not move the window.
- R3: The time base follows x^8+x^6+x^5+x^4+1. It is reloaded with a nonzero seed at each accepted start and steps once per window cycle. A comparator that is low in window cycle k-1 and high in window cycle k has its raw result decoded to k. A comparator already high in cycle 0 decodes to 0.
- R4: Only the first rising transition of a comparator within a window is captured. Later falls and rises in the same window do not change that word's result.
- R5: A word whose comparator does not rise within the window reports 63, whatever its offset.
- R6: With `cal_i` high at the accepted start, each word stores its raw decoded result as its offset and also presents that raw value on its result field.
- R7: With `cal_i` low, a tripped word reports its raw decoded value minus its stored offset, clamped at 0.
- R8: `valid_o` is high for exactly one cycle, the second cycle after window cycle 63. All results change at the same edge that raises `valid_o` and then hold until the next completion.
- R9: Word w occupies bits [6w+5 : 6w] of `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a conversion window |
| cal_i | input | 1 | Mode sampled at start: 1 selects calibration, 0 selects normal conversion |
| cmp_i | input | WORDS | Per-word comparator outputs |
| valid_o | output | 1 | One-cycle pulse when all results are fresh |
| result_o | output | WORDS*RES_W | Packed per-word 6-bit results |

## Verification
Two of the block's functions can fall in the same cycle: the first trip of a comparator, and the closing of the window on cycle 63. The bench provokes this by raising a comparator exactly on the last window cycle of a trimmed word. It requires the captured cycle minus the offset, which differs from the full-scale value that a missed trip would give. A second collision, a start pulse in the middle of a window, is judged by requiring that the valid pulse still arrives at the cycle counted from the first start and that the results match that first window.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int LFSR_W = 8;

    // one Fibonacci step, taps for x^8+x^6+x^5+x^4+1
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    // state reached n steps after the seed
    function automatic logic [LFSR_W-1:0] lfsr_after(input logic [LFSR_W-1:0] seed, input int n);
        logic [LFSR_W-1:0] s;
        s = seed;
        for (int j = 0; j < n; j++) s = lfsr_step(s);
        return s;
    endfunction

endpackage

// File: rtl/lsc_timer.sv
module lsc_timer
    import lsc_pkg::*;
#(
    parameter int              WINDOW = 64,
    parameter logic [LFSR_W-1:0] SEED = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cal_i,
    output logic              start_ok_o,
    output logic              busy_o,
    output logic              fin_o,
    output logic              valid_o,
    output logic              cal_o,
    output logic [LFSR_W-1:0] lfsr_o
);
    localparam int CNT_W = $clog2(WINDOW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    typedef struct packed {
        logic              busy;
        logic              fin;
        logic              valid;
        logic              cal;
        logic [CNT_W-1:0]  cnt;
        logic [LFSR_W-1:0] lfsr;
    } tmr_t;

    tmr_t st_d, st_q;
    logic start_ok;

    always_comb begin
        st_d       = st_q;
        start_ok   = start_i && !st_q.busy && !st_q.fin;
        st_d.fin   = st_q.busy && (st_q.cnt == LAST);
        st_d.valid = st_q.fin;
        if (start_ok) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.lfsr = SEED;
            st_d.cal  = cal_i;
        end else if (st_q.busy) begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.lfsr = lfsr_step(st_q.lfsr);
            if (st_q.cnt == LAST) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{busy: 1'b0, fin: 1'b0, valid: 1'b0, cal: 1'b0, cnt: '0, lfsr: SEED};
        else        st_q <= st_d;
    end

    assign start_ok_o = start_ok;
    assign busy_o     = st_q.busy;
    assign fin_o      = st_q.fin;
    assign valid_o    = st_q.valid;
    assign cal_o      = st_q.cal;
    assign lfsr_o     = st_q.lfsr;

    a_r2_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt == LAST) |=> (!st_q.busy && st_q.fin));
    a_r2_window_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != LAST) |=> st_q.busy);
    a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.lfsr != '0));
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);
    a_r8_fin_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fin |=> st_q.valid);
endmodule

// File: rtl/lsc_decode.sv
module lsc_decode
    import lsc_pkg::*;
#(
    parameter int                WINDOW = 64,
    parameter int                RES_W  = 6,
    parameter logic [LFSR_W-1:0] SEED   = 8'h01
) (
    input  logic [LFSR_W-1:0] code_i,
    output logic [RES_W-1:0]  idx_o,
    output logic              hit_o
);
    logic [WINDOW-1:0] match;

    for (genvar i = 0; i < WINDOW; i++) begin : g_key
        localparam logic [LFSR_W-1:0] KEY = lfsr_after(SEED, i);
        assign match[i] = (code_i == KEY);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < WINDOW; i++)
            if (match[i]) idx_o = RES_W'(i);
        hit_o = |match;
        if (!$isunknown(code_i))
            a_r3_key_unique: assert ($onehot0(match));
    end
endmodule

// File: rtl/lsc_word.sv
module lsc_word
    import lsc_pkg::*;
#(
    parameter int                WINDOW = 64,
    parameter int                RES_W  = 6,
    parameter logic [LFSR_W-1:0] SEED   = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok_i,
    input  logic              busy_i,
    input  logic              fin_i,
    input  logic              cal_i,
    input  logic [LFSR_W-1:0] lfsr_i,
    input  logic              cmp_i,
    output logic [RES_W-1:0]  result_o
);
    localparam logic [RES_W-1:0] FULL = RES_W'(WINDOW - 1);

    typedef struct packed {
        logic              prev;
        logic              hit;
        logic [LFSR_W-1:0] cap;
        logic [RES_W-1:0]  off;
        logic [RES_W-1:0]  res;
    } wrd_t;

    wrd_t st_d, st_q;
    logic [RES_W-1:0] dec_idx, raw;
    logic             dec_hit, tripped;

    lsc_decode #(.WINDOW(WINDOW), .RES_W(RES_W), .SEED(SEED)) dec_i (
        .code_i (st_q.cap),
        .idx_o  (dec_idx),
        .hit_o  (dec_hit)
    );

    always_comb begin
        st_d    = st_q;
        tripped = st_q.hit && dec_hit;
        raw     = tripped ? dec_idx : FULL;
        if (start_ok_i) begin
            st_d.prev = 1'b0;
            st_d.hit  = 1'b0;
            st_d.cap  = '0;
        end else if (busy_i) begin
            st_d.prev = cmp_i;
            if (cmp_i && !st_q.prev && !st_q.hit) begin
                st_d.hit = 1'b1;
                st_d.cap = lfsr_i;
            end
        end
        if (fin_i) begin
            if (cal_i) begin
                st_d.off = raw;
                st_d.res = raw;
            end else if (!tripped) begin
                st_d.res = FULL;
            end else begin
                st_d.res = (raw >= st_q.off) ? (raw - st_q.off) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;

    a_r4_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && st_q.hit) |=> $stable(st_q.cap));
    a_r6_offset_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_i && cal_i) |=> (st_q.off == st_q.res));
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> $stable(st_q.res));
endmodule

// File: rtl/lfsr_slope_adc.sv
module lfsr_slope_adc
    import lsc_pkg::*;
#(
    parameter int                WORDS  = 4,
    parameter int                WINDOW = 64,
    parameter int                RES_W  = 6,
    parameter logic [LFSR_W-1:0] SEED   = 8'h01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   cal_i,
    input  logic [WORDS-1:0]       cmp_i,
    output logic                   valid_o,
    output logic [WORDS*RES_W-1:0] result_o
);
    logic              start_ok, busy, fin, cal_q;
    logic [LFSR_W-1:0] lfsr;

    lsc_timer #(.WINDOW(WINDOW), .SEED(SEED)) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cal_i      (cal_i),
        .start_ok_o (start_ok),
        .busy_o     (busy),
        .fin_o      (fin),
        .valid_o    (valid_o),
        .cal_o      (cal_q),
        .lfsr_o     (lfsr)
    );

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        lsc_word #(.WINDOW(WINDOW), .RES_W(RES_W), .SEED(SEED)) word_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_ok_i (start_ok),
            .busy_i     (busy),
            .fin_i      (fin),
            .cal_i      (cal_q),
            .lfsr_i     (lfsr),
            .cmp_i      (cmp_i[w]),
            .result_o   (result_o[w*RES_W +: RES_W])
        );
    end
endmodule

// File: tb/lfsr_slope_adc_tb_top.sv
module lfsr_slope_adc_tb_top;
    localparam int W = 4;
    localparam int NEVER = 1000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cal_i = 1'b0;
    logic [W-1:0] cmp_i = '0;
    logic         valid_o;
    logic [W*6-1:0] result_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int trip [W];
    int offs [W];
    int got  [W];

    always #5 clk = ~clk;

    lfsr_slope_adc dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_i(cal_i),
        .cmp_i(cmp_i), .valid_o(valid_o), .result_o(result_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R9: word w on bits [6w+5:6w]
    function automatic int field(input int w);
        return int'(result_o[w*6 +: 6]);
    endfunction

    // Runs one window. glitch: comparator falls two cycles after trip then rises again (R4).
    // restart: a second start pulse inside the window (R2).
    task automatic convert(input bit cal, input bit glitch, input bit restart);
        @(negedge clk); start_i = 1'b1; cal_i = cal;
        @(negedge clk); start_i = 1'b0; cal_i = 1'b0;
        for (int k = 0; k < 64; k++) begin
            for (int w = 0; w < W; w++)
                cmp_i[w] = (k >= trip[w]) && !(glitch && k == trip[w] + 2);
            start_i = restart && (k == 20);
            @(negedge clk);
        end
        cmp_i = '0; start_i = 1'b0;
        check("R8 valid low in finishing cycle", int'(valid_o), 0);
        @(negedge clk);
        check("R8 valid high two cycles after window", int'(valid_o), 1);
        for (int w = 0; w < W; w++) got[w] = field(w);
        @(negedge clk);
        check("R8 valid single cycle", int'(valid_o), 0);
        for (int w = 0; w < W; w++) check("R8 results held", field(w), got[w]);
    endtask

    task automatic t_reset;
        check("R1 valid after reset", int'(valid_o), 0);
        for (int w = 0; w < W; w++) check("R1 result after reset", field(w), 0);
    endtask

    task automatic t_plain;
        trip = '{5, 17, 40, 0};
        convert(1'b0, 1'b0, 1'b0);
        for (int w = 0; w < W; w++) check("R3 untrimmed decode equals trip cycle", got[w], trip[w]);
    endtask

    task automatic t_calibrate;
        offs = '{2, 0, 7, 3};
        trip = offs;
        convert(1'b1, 1'b0, 1'b0);
        for (int w = 0; w < W; w++) check("R6 calibration shows raw offset", got[w], offs[w]);
    endtask

    task automatic t_trimmed;
        int ideal [W];
        ideal = '{10, 33, 1, 50};
        for (int w = 0; w < W; w++) trip[w] = ideal[w] + offs[w];
        convert(1'b0, 1'b0, 1'b0);
        for (int w = 0; w < W; w++) check("R7 trimmed result equals ideal", got[w], ideal[w]);
    endtask

    task automatic t_clamp;
        trip = '{0, 4, 1, 2};
        convert(1'b0, 1'b0, 1'b0);
        check("R7 clamp at zero w0", got[0], 0);
        check("R7 no offset w1", got[1], 4);
        check("R7 clamp at zero w2", got[2], 0);
        check("R7 clamp at zero w3", got[3], 0);
    endtask

    task automatic t_edges;
        // word 3 trips on the last window cycle, colliding with window close
        trip = '{NEVER, 63, NEVER, 63};
        convert(1'b0, 1'b0, 1'b0);
        check("R5 no trip full scale w0", got[0], 63);
        check("R3 trip on last cycle w1", got[1], 63);
        check("R5 no trip full scale w2 despite offset", got[2], 63);
        check("R7 last-cycle trip trimmed w3", got[3], 60);
    endtask

    task automatic t_glitch;
        trip = '{12, 30, 20, 45};
        convert(1'b0, 1'b1, 1'b0);
        for (int w = 0; w < W; w++)
            check("R4 later toggles ignored", got[w], trip[w] - offs[w]);
    endtask

    task automatic t_restart;
        trip = '{8, 25, 40, 60};
        convert(1'b0, 1'b0, 1'b1);
        for (int w = 0; w < W; w++)
            check("R2 mid-window start ignored", got[w], trip[w] - offs[w]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_plain;
        t_calibrate;
        t_trimmed;
        t_clamp;
        t_edges;
        t_glitch;
        t_restart;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule